// File: doc/BRIEF.md
# Page-Walk Memory Request Scheduler

This block sits between a page-table walk engine and a memory port. The memory port may refuse a request in the cycle it is offered, and may answer an accepted request with a negative acknowledgement (nack) instead of real data. The scheduler holds at most one pending table read and a small last-in-first-out stack of pending write-backs, such as entries whose accessed bit was set. It offers them to the port one per cycle, with the read always ahead of any write. After a refusal it stays silent until the port pulses retry. A nacked request is offered again in the same cycle the nack arrives. If that second offer is also refused, the request goes back into the read slot or the write stack.

The walk engine starts a walk by pushing its first read. Every real read response is passed straight through to the engine. The engine pushes its next read and any write-back in that same cycle. A counter tracks every accepted request that has not yet been answered. The scheduler pulses walk completion once the walk has started, the counter is zero, the read slot is empty and the write stack is empty.

Top module: `wsched_top`

## Requirements
- R1: After reset no request is offered (`mem_req_valid`=0), `walk_done`=0 and `wb_full`=0.
- R2: When a read is pending and no nack is being re-offered, the offered request is the read (`mem_req_write`=0), even if writes are queued.
- R3: Queued write-backs are offered newest first: the most recently pushed write that has not yet been accepted goes next.
- R4: An offer with `mem_req_ready`=0 is a refusal. From the next cycle on, nothing is offered until a `mem_retry` pulse. In the cycle after that pulse, the same request is offered again.
- R5: A response with `mem_rsp_nack`=1 makes the block offer that request in the same cycle. The offer has the same `mem_req_write`, address and data as the response fields, and it is made even while retrying.
- R6: If the same-cycle re-offer of a nack is refused, a read returns to the read slot and a write returns to the top of the write stack. Retrying is set, and after the retry pulse that request is offered again.
- R7: `wk_rsp_valid` is high, with `wk_rsp_data`=`mem_rsp_data`, in exactly the cycles of a non-nacked response with `mem_rsp_write`=0. Write responses and nacks are not forwarded.
- R8: `walk_done` pulses high for exactly one cycle, in the cycle after the last response of a started walk, when the read slot and the write stack are also empty.
- R9: `wb_full` is high while the write stack holds WQ_DEPTH (default 4) entries and low otherwise. The engine must not push a write while it is high.
- R10: Every accepted offer adds one to the outstanding count and every response (nack included) removes one. `walk_done` stays low while the count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wk_rd_push | input | 1 | Engine loads the read slot |
| wk_rd_addr | input | AW | Address of the table read |
| wk_wb_push | input | 1 | Engine pushes a write-back |
| wk_wb_addr | input | AW | Write-back address |
| wk_wb_data | input | DW | Write-back data |
| wb_full | output | 1 | Write stack holds WQ_DEPTH entries |
| wk_rsp_valid | output | 1 | Read data for the engine this cycle |
| wk_rsp_data | output | DW | Forwarded read data |
| walk_done | output | 1 | One-cycle walk completion pulse |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_data | output | DW | Write data (zero for reads) |
| mem_req_ready | input | 1 | Memory takes the offer; low = refusal |
| mem_retry | input | 1 | Single-cycle pulse ending a refusal |
| mem_rsp_valid | input | 1 | Response for an accepted request |
| mem_rsp_nack | input | 1 | Response is a nack |
| mem_rsp_write | input | 1 | Response belongs to a write |
| mem_rsp_addr | input | AW | Address of the answered request |
| mem_rsp_data | input | DW | Read data, or the write data of a nacked write |

## Verification
The bench targets the moments where two things compete:
- A read pushed while writes are stacked behind a refusal. A scheduler with fair or queue-first order would send a write first.
- Four writes stacked at once. A first-in-first-out stack would release the oldest.
- A nack arriving while retrying. A design that honoured the retry gate here would stall the nack instead of re-offering it.
- A refused nack re-offer. A design that dropped it would never send it again, and one that filed it in the wrong place would re-offer a read as a write.
- A read response that comes back while writes are still outstanding. A design that tested only the read slot and the stack would pulse completion early.

// File: rtl/wsched_pkg.sv
// Package: shared types of the walk request scheduler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package wsched_pkg;

    // Source driving the memory request port in a given cycle.
    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_NACK  = 2'd1,
        SEL_READ  = 2'd2,
        SEL_QUEUE = 2'd3
    } sel_t;

endpackage

// File: rtl/wsched_lifo.sv
// Module: wsched_lifo
// Small last-in-first-out store for write-backs. A push and a pop in the
// same cycle replace the top entry. Assumes the caller never pushes while
// full without popping, and never pops while empty.
module wsched_lifo #(
    parameter int DEPTH = 4,
    parameter int W     = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] top_data,
    output logic         full,
    output logic         empty
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [CW-1:0] cnt;
    logic [PTRW-1:0] top_idx;
    logic [PTRW-1:0] wr_idx;

    // Index of the newest entry and of the next free slot.
    always_comb begin
        top_idx = PTRW'(cnt - 1'b1);
        wr_idx  = PTRW'(cnt);
    end

    assign top_data = slots[top_idx];
    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);

    // Occupancy update: replace, grow or shrink.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push && !pop) begin
            cnt <= cnt + 1'b1;
        end else if (pop && !push) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Entry storage: a replace writes the top, a plain push writes above it.
    always_ff @(posedge clk) begin
        if (push && pop) begin
            slots[top_idx] <= push_data;
        end else if (push) begin
            slots[wr_idx] <= push_data;
        end
    end
endmodule

// File: rtl/wsched_outstanding.sv
// Module: wsched_outstanding
// Counts accepted requests that are still unanswered. Assumes the port
// never answers more requests than it accepted.
module wsched_outstanding #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          zero
);
    assign zero = (count == '0);

    // Net change: one up per acceptance, one down per response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + CW'(inc) - CW'(dec);
        end
    end
endmodule

// File: rtl/wsched_port_arb.sv
// Module: wsched_port_arb
// Chooses what drives the memory request port and keeps the sticky
// retrying flag. A nack re-offer overrides everything, retrying included.
// Otherwise the read slot beats the write stack, and nothing is offered
// while retrying.
module wsched_port_arb
    import wsched_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nack_in,
    input  logic          nack_write,
    input  logic [AW-1:0] nack_addr,
    input  logic [DW-1:0] nack_data,
    input  logic          rd_vld,
    input  logic [AW-1:0] rd_addr,
    input  logic          q_avail,
    input  logic [AW-1:0] q_addr,
    input  logic [DW-1:0] q_data,
    input  logic          mem_req_ready,
    input  logic          mem_retry,
    output sel_t          sel,
    output logic          retrying,
    output logic          mem_req_valid,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data
);
    // Priority choice of the request source.
    always_comb begin
        if (nack_in) begin
            sel = SEL_NACK;
        end else if (retrying) begin
            sel = SEL_IDLE;
        end else if (rd_vld) begin
            sel = SEL_READ;
        end else if (q_avail) begin
            sel = SEL_QUEUE;
        end else begin
            sel = SEL_IDLE;
        end
    end

    // Port mux for the chosen source.
    always_comb begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_data  = '0;
        unique case (sel)
            SEL_NACK: begin
                mem_req_write = nack_write;
                mem_req_addr  = nack_addr;
                mem_req_data  = nack_data;
            end
            SEL_READ: begin
                mem_req_addr  = rd_addr;
            end
            SEL_QUEUE: begin
                mem_req_write = 1'b1;
                mem_req_addr  = q_addr;
                mem_req_data  = q_data;
            end
            default: begin
                mem_req_valid = 1'b0;
            end
        endcase
    end

    // Sticky retrying flag: a refusal sets it, a retry pulse clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retrying <= 1'b0;
        end else if (mem_req_valid && !mem_req_ready) begin
            retrying <= 1'b1;
        end else if (mem_retry) begin
            retrying <= 1'b0;
        end
    end
endmodule

// File: rtl/wsched_top.sv
// Module: wsched_top
// Walk memory request scheduler. Holds one pending read and a stack of
// write-backs, offers them to a memory port that may refuse or nack,
// forwards read data to the walk engine and pulses completion when the
// walk has nothing left in flight. Assumes the engine pushes its next read
// and write-back only in the cycle of a forwarded read response, and that
// retry and nack are single-cycle pulses.
module wsched_top
    import wsched_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 64,
    parameter int WQ_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wk_rd_push,
    input  logic [AW-1:0] wk_rd_addr,
    input  logic          wk_wb_push,
    input  logic [AW-1:0] wk_wb_addr,
    input  logic [DW-1:0] wk_wb_data,
    output logic          wb_full,
    output logic          wk_rsp_valid,
    output logic [DW-1:0] wk_rsp_data,
    output logic          walk_done,
    output logic          mem_req_valid,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data,
    input  logic          mem_req_ready,
    input  logic          mem_retry,
    input  logic          mem_rsp_valid,
    input  logic          mem_rsp_nack,
    input  logic          mem_rsp_write,
    input  logic [AW-1:0] mem_rsp_addr,
    input  logic [DW-1:0] mem_rsp_data
);
    localparam int EW = AW + DW;
    localparam int CW = $clog2(WQ_DEPTH + 2) + 1;

    sel_t          sel;
    logic          retrying;
    logic          rd_vld;
    logic [AW-1:0] rd_addr;
    logic          active;
    logic          nack_in;
    logic          accepted;
    logic          nack_refused;
    logic          rd_sent;
    logic          q_pop;
    logic          q_push;
    logic [EW-1:0] q_push_data;
    logic [EW-1:0] q_top;
    logic          q_full;
    logic          q_empty;
    logic [CW-1:0] out_count;
    logic          out_zero;

    // Event decode for this cycle.
    always_comb begin
        nack_in      = mem_rsp_valid && mem_rsp_nack;
        accepted     = mem_req_valid && mem_req_ready;
        nack_refused = nack_in && !mem_req_ready;
        rd_sent      = accepted && (sel == SEL_READ);
        q_pop        = accepted && (sel == SEL_QUEUE);
        q_push       = wk_wb_push || (nack_refused && mem_rsp_write);
        q_push_data  = (nack_refused && mem_rsp_write) ? {mem_rsp_addr, mem_rsp_data}
                                                       : {wk_wb_addr, wk_wb_data};
    end

    // Read slot: loaded by the engine or by a refused read nack, freed on send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_addr <= '0;
        end else if (wk_rd_push) begin
            rd_vld  <= 1'b1;
            rd_addr <= wk_rd_addr;
        end else if (nack_refused && !mem_rsp_write) begin
            rd_vld  <= 1'b1;
            rd_addr <= mem_rsp_addr;
        end else if (rd_sent) begin
            rd_vld  <= 1'b0;
        end
    end

    // Walk-in-progress flag: set by any engine push, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (wk_rd_push || wk_wb_push) begin
            active <= 1'b1;
        end else if (walk_done) begin
            active <= 1'b0;
        end
    end

    // Outputs to the walk engine.
    assign walk_done    = active && out_zero && !rd_vld && q_empty;
    assign wk_rsp_valid = mem_rsp_valid && !mem_rsp_nack && !mem_rsp_write;
    assign wk_rsp_data  = mem_rsp_data;
    assign wb_full      = q_full;

    wsched_lifo #(
        .DEPTH (WQ_DEPTH),
        .W     (EW)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_push_data),
        .pop       (q_pop),
        .top_data  (q_top),
        .full      (q_full),
        .empty     (q_empty)
    );

    wsched_outstanding #(
        .CW (CW)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accepted),
        .dec   (mem_rsp_valid),
        .count (out_count),
        .zero  (out_zero)
    );

    wsched_port_arb #(
        .AW (AW),
        .DW (DW)
    ) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .nack_in       (nack_in),
        .nack_write    (mem_rsp_write),
        .nack_addr     (mem_rsp_addr),
        .nack_data     (mem_rsp_data),
        .rd_vld        (rd_vld),
        .rd_addr       (rd_addr),
        .q_avail       (!q_empty),
        .q_addr        (q_top[EW-1:DW]),
        .q_data        (q_top[DW-1:0]),
        .mem_req_ready (mem_req_ready),
        .mem_retry     (mem_retry),
        .sel           (sel),
        .retrying      (retrying),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_data  (mem_req_data)
    );
endmodule

// File: rtl/wsched_chk.sv
// Module: wsched_chk
// Temporal checks on the scheduler, attached to wsched_top by bind.
// Assumes the environment obeys the handshake rules in the brief.
module wsched_chk #(
    parameter int AW = 32,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_req_write,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_rsp_valid,
    input logic          mem_rsp_nack,
    input logic          mem_rsp_write,
    input logic [AW-1:0] mem_rsp_addr,
    input logic          retrying,
    input logic          rd_vld,
    input logic          q_full,
    input logic          wk_wb_push,
    input logic          wk_rsp_valid,
    input logic          walk_done,
    input logic [CW-1:0] out_count
);
    logic nack_now;
    assign nack_now = mem_rsp_valid && mem_rsp_nack;

    assert_read_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && mem_req_valid && !nack_now) |-> !mem_req_write);

    assert_refusal_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> retrying);

    assert_silent_retrying_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (retrying && !nack_now) |-> !mem_req_valid);

    assert_nack_reoffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nack_now |-> (mem_req_valid && (mem_req_write == mem_rsp_write)
                      && (mem_req_addr == mem_rsp_addr)));

    assert_read_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_now && !mem_rsp_write && !mem_req_ready) |=> rd_vld);

    assert_forward_only_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wk_rsp_valid |-> (mem_rsp_valid && !mem_rsp_nack && !mem_rsp_write));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wk_wb_push |-> !q_full);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> ((out_count == '0) && !rd_vld));

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (out_count != '0));
endmodule

bind wsched_top wsched_chk #(
    .AW (AW),
    .CW (CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_nack  (mem_rsp_nack),
    .mem_rsp_write (mem_rsp_write),
    .mem_rsp_addr  (mem_rsp_addr),
    .retrying      (retrying),
    .rd_vld        (rd_vld),
    .q_full        (q_full),
    .wk_wb_push    (wk_wb_push),
    .wk_rsp_valid  (wk_rsp_valid),
    .walk_done     (walk_done),
    .out_count     (out_count)
);

// File: tb/tb_wsched_top.sv
// Directed bench for wsched_top: one task per scenario, each checking itself.
module tb_wsched_top;
    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wk_rd_push;
    logic [AW-1:0] wk_rd_addr;
    logic          wk_wb_push;
    logic [AW-1:0] wk_wb_addr;
    logic [DW-1:0] wk_wb_data;
    logic          wb_full;
    logic          wk_rsp_valid;
    logic [DW-1:0] wk_rsp_data;
    logic          walk_done;
    logic          mem_req_valid;
    logic          mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_data;
    logic          mem_req_ready;
    logic          mem_retry;
    logic          mem_rsp_valid;
    logic          mem_rsp_nack;
    logic          mem_rsp_write;
    logic [AW-1:0] mem_rsp_addr;
    logic [DW-1:0] mem_rsp_data;

    int vectors     = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    wsched_top #(.AW(AW), .DW(DW), .WQ_DEPTH(4)) dut (
        .clk (clk), .rst_n (rst_n),
        .wk_rd_push (wk_rd_push), .wk_rd_addr (wk_rd_addr),
        .wk_wb_push (wk_wb_push), .wk_wb_addr (wk_wb_addr), .wk_wb_data (wk_wb_data),
        .wb_full (wb_full), .wk_rsp_valid (wk_rsp_valid), .wk_rsp_data (wk_rsp_data),
        .walk_done (walk_done),
        .mem_req_valid (mem_req_valid), .mem_req_write (mem_req_write),
        .mem_req_addr (mem_req_addr), .mem_req_data (mem_req_data),
        .mem_req_ready (mem_req_ready), .mem_retry (mem_retry),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_nack (mem_rsp_nack),
        .mem_rsp_write (mem_rsp_write), .mem_rsp_addr (mem_rsp_addr),
        .mem_rsp_data (mem_rsp_data)
    );

    // Compare one value and log a miscompare.
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Move to the next falling edge and return all pulses to idle.
    task automatic step();
        @(negedge clk);
        wk_rd_push = 0; wk_wb_push = 0; mem_retry = 0;
        mem_rsp_valid = 0; mem_rsp_nack = 0; mem_rsp_write = 0;
        mem_req_ready = 1;
    endtask

    // Let combinational outputs settle after driving.
    task automatic settle();
        #2;
    endtask

    // Check an offered request.
    task automatic expect_req(input string tag, input logic wr, input logic [AW-1:0] a,
                              input logic [DW-1:0] d);
        chk({tag, " valid"}, 64'(mem_req_valid), 64'd1);
        chk({tag, " write"}, 64'(mem_req_write), 64'(wr));
        chk({tag, " addr"},  64'(mem_req_addr), 64'(a));
        if (wr) chk({tag, " data"}, mem_req_data, d);
    endtask

    task automatic rsp(input logic nack, input logic wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        mem_rsp_valid = 1; mem_rsp_nack = nack; mem_rsp_write = wr;
        mem_rsp_addr = a; mem_rsp_data = d;
    endtask

    task automatic t_reset();
        rst_n = 0;
        step(); step(); step();
        rst_n = 1;
        settle();
        chk("R1 req idle", 64'(mem_req_valid), 0);
        chk("R1 done low", 64'(walk_done), 0);
        chk("R1 full low", 64'(wb_full), 0);
    endtask

    task automatic t_two_level_walk();
        step(); wk_rd_push = 1; wk_rd_addr = 32'h100;
        step(); settle(); expect_req("R2 first read", 0, 32'h100, 0);
        step(); rsp(0, 0, 32'h100, 64'hA001); settle();
        chk("R7 fwd valid", 64'(wk_rsp_valid), 1);
        chk("R7 fwd data", wk_rsp_data, 64'hA001);
        wk_rd_push = 1; wk_rd_addr = 32'h208;
        wk_wb_push = 1; wk_wb_addr = 32'h100; wk_wb_data = 64'hA021;
        step(); settle(); expect_req("R2 read ahead of wb", 0, 32'h208, 0);
        chk("R10 busy", 64'(walk_done), 0);
        step(); settle(); expect_req("R3 wb", 1, 32'h100, 64'hA021);
        step(); rsp(0, 1, 32'h100, 0); settle();
        chk("R7 write rsp not fwd", 64'(wk_rsp_valid), 0);
        chk("R10 read outstanding", 64'(walk_done), 0);
        step(); rsp(0, 0, 32'h208, 64'hB002); settle();
        chk("R7 fwd data 2", wk_rsp_data, 64'hB002);
        step(); settle(); chk("R8 done", 64'(walk_done), 1);
        step(); settle(); chk("R8 done one cycle", 64'(walk_done), 0);
    endtask

    task automatic t_priority_stack();
        step(); wk_wb_push = 1; wk_wb_addr = 32'h10; wk_wb_data = 64'h1;
        step(); settle(); expect_req("R3 w1 offered", 1, 32'h10, 64'h1);
        mem_req_ready = 0;
        wk_wb_push = 1; wk_wb_addr = 32'h20; wk_wb_data = 64'h2;
        step(); settle(); chk("R4 silent", 64'(mem_req_valid), 0);
        wk_rd_push = 1; wk_rd_addr = 32'h300;
        step(); settle(); chk("R4 silent 2", 64'(mem_req_valid), 0);
        wk_wb_push = 1; wk_wb_addr = 32'h30; wk_wb_data = 64'h3;
        step(); settle(); chk("R9 three not full", 64'(wb_full), 0);
        wk_wb_push = 1; wk_wb_addr = 32'h40; wk_wb_data = 64'h4;
        step(); settle(); chk("R9 four full", 64'(wb_full), 1);
        chk("R4 still silent", 64'(mem_req_valid), 0);
        mem_retry = 1;
        step(); settle(); expect_req("R2 read beats stack", 0, 32'h300, 0);
        step(); settle(); expect_req("R3 newest", 1, 32'h40, 64'h4);
        step(); settle(); chk("R9 after pop", 64'(wb_full), 0);
        expect_req("R3 next", 1, 32'h30, 64'h3);
        step(); settle(); expect_req("R3 next 2", 1, 32'h20, 64'h2);
        step(); settle(); expect_req("R3 oldest", 1, 32'h10, 64'h1);
        step(); rsp(0, 0, 32'h300, 64'hC3); settle();
        chk("R7 fwd", wk_rsp_data, 64'hC3);
        for (int i = 0; i < 4; i++) begin
            step(); rsp(0, 1, 32'h10, 0); settle();
            chk("R10 writes outstanding", 64'(walk_done), 0);
        end
        step(); settle(); chk("R8 done after last write", 64'(walk_done), 1);
    endtask

    task automatic t_nack_read();
        step(); wk_rd_push = 1; wk_rd_addr = 32'h400;
        step(); settle(); expect_req("R2 read", 0, 32'h400, 0);
        step(); rsp(1, 0, 32'h400, 0); settle();
        expect_req("R5 nack read reoffer", 0, 32'h400, 0);
        chk("R7 nack not fwd", 64'(wk_rsp_valid), 0);
        step(); settle(); chk("R10 still one out", 64'(walk_done), 0);
        chk("R10 no extra offer", 64'(mem_req_valid), 0);
        step(); rsp(0, 0, 32'h400, 64'hD4);
        step(); settle(); chk("R8 done", 64'(walk_done), 1);
    endtask

    task automatic t_nack_retrying();
        step(); wk_rd_push = 1; wk_rd_addr = 32'h600;
        step(); settle(); expect_req("R2 read", 0, 32'h600, 0);
        wk_wb_push = 1; wk_wb_addr = 32'h60; wk_wb_data = 64'h66;
        step(); settle(); expect_req("R4 wb offered", 1, 32'h60, 64'h66);
        mem_req_ready = 0;
        step(); settle(); chk("R4 silent", 64'(mem_req_valid), 0);
        rsp(1, 0, 32'h600, 0); settle();
        expect_req("R5 nack during retrying", 0, 32'h600, 0);
        step(); settle(); chk("R4 silent after nack", 64'(mem_req_valid), 0);
        mem_retry = 1;
        step(); settle(); expect_req("R4 same after retry", 1, 32'h60, 64'h66);
        step(); rsp(1, 1, 32'h60, 64'h66); mem_req_ready = 0; settle();
        expect_req("R5 nack write reoffer", 1, 32'h60, 64'h66);
        step(); settle(); chk("R6 retrying", 64'(mem_req_valid), 0);
        mem_retry = 1;
        step(); settle(); expect_req("R6 write back in stack", 1, 32'h60, 64'h66);
        step(); rsp(0, 1, 32'h60, 0);
        step(); rsp(0, 0, 32'h600, 64'hE6); settle();
        chk("R10 not yet", 64'(walk_done), 0);
        step(); settle(); chk("R8 done", 64'(walk_done), 1);
    endtask

    task automatic t_nack_read_refused();
        step(); wk_rd_push = 1; wk_rd_addr = 32'h700;
        step(); settle(); expect_req("R2 read", 0, 32'h700, 0);
        step(); rsp(1, 0, 32'h700, 0); mem_req_ready = 0; settle();
        expect_req("R5 reoffer", 0, 32'h700, 0);
        step(); settle(); chk("R6 silent", 64'(mem_req_valid), 0);
        chk("R6 not done", 64'(walk_done), 0);
        mem_retry = 1;
        step(); settle(); expect_req("R6 read back in slot", 0, 32'h700, 0);
        step(); rsp(0, 0, 32'h700, 64'hF7);
        step(); settle(); chk("R8 done", 64'(walk_done), 1);
    endtask

    initial begin
        wk_rd_addr = 0; wk_wb_addr = 0; wk_wb_data = 0;
        mem_rsp_addr = 0; mem_rsp_data = 0;
        wk_rd_push = 0; wk_wb_push = 0; mem_retry = 0;
        mem_rsp_valid = 0; mem_rsp_nack = 0; mem_rsp_write = 0; mem_req_ready = 1;
        t_reset();
        t_two_level_walk();
        step(); step();
        t_priority_stack();
        step(); step();
        t_nack_read();
        step(); step();
        t_nack_retrying();
        step(); step();
        t_nack_read_refused();
        step();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        #(20 * 200000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule